// File: doc/BRIEF.md
# Circular DMA Address Sequencer

This block produces the word addresses that one direction of an audio DMA channel walks through in a circular memory buffer. Software programs three boundary addresses: where the buffer starts, a notification point inside it, and its last word. All three are forced to word alignment and are never allowed below `0x2000_0000`. When the DMA enable goes from low to high, the sequencer copies the start address into its private copy and into the current address. After that, a later write to the start register changes only the stored value. The running pointer is not redirected until the next enable edge.

The FIFO side asks for a word by holding `fifo_req`. The sequencer then offers a transfer on `xfer_valid`, with the target address on `cur_addr`. The bus side accepts that transfer with `xfer_ready`. The pointer moves on only when both are high in the same cycle. While `xfer_valid` is high and `xfer_ready` is low, the address holds. A `xfer_ready` with no valid offer has no effect. After the transfer at the end address, the pointer returns to the latched start, so the buffer repeats.

Two sticky flags report when the pointer reaches the notification point or the end address. This allows half-buffer and full-buffer refills in a double-buffer scheme. Each flag is cleared by writing 1 to its clear bit. Each flag drives the interrupt line only when its own enable bit is set. For stereo samples 24 or 32 bits wide, each channel takes one word. The buffer should therefore hold an even number of words, so that left and right stay in their slots after the wrap.

Top module: `dma_circ_seq`

## Requirements
- R1: After reset, `cur_addr` is `0x2000_0000`, `flags` is 0, `irq` is 0 and `xfer_valid` is 0.
- R2: A configuration write clears bits [1:0] of the value. A value below `0x2000_0000` is stored as `0x2000_0000`. `reg_sel` selects the register: 0 is start, 1 is threshold, 2 is end, and 3 is ignored.
- R3: On the first clock edge where `dma_en` is high after a low, `cur_addr` takes the stored start address, and the sequencer becomes armed.
- R4: A write to the start register while enable stays high leaves `cur_addr` unchanged. It also leaves the wrap target unchanged.
- R5: `xfer_valid` is high exactly when `dma_en` is high, the sequencer is armed and `fifo_req` is high. While `xfer_valid` is high and `xfer_ready` is low, `cur_addr` holds.
- R6: When a transfer is accepted at an address other than the end address, `cur_addr` increases by 4 at the next edge.
- R7: When a transfer is accepted at the end address, `cur_addr` returns to the start address latched at the last enable edge.
- R8: `flags[0]` (threshold) and `flags[1]` (end) are set one cycle after `cur_addr` first equals the respective address while armed. They stay set until cleared.
- R9: A flag sets only once per arrival at its address. After it is cleared while `cur_addr` still equals that address, it stays clear.
- R10: A 1 on `flag_clr[i]` clears `flags[i]` at the next edge. A 0 leaves the flag unchanged.
- R11: `irq` is the OR of `flags[i] & irq_en[i]` over both flags.
- R12: Dropping `dma_en` forces `xfer_valid` low in the same cycle and freezes `cur_addr` for reading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Configuration write strobe |
| reg_sel | input | 2 | Register select: 0 start, 1 threshold, 2 end |
| reg_wdata | input | 32 | Configuration write data |
| dma_en | input | 1 | DMA enable; a rising edge loads the start address |
| fifo_req | input | 1 | FIFO side requests one word transfer |
| xfer_valid | output | 1 | Transfer offered at `cur_addr` |
| xfer_ready | input | 1 | Bus side accepts the offered transfer |
| cur_addr | output | 32 | Current DMA address |
| flag_clr | input | 2 | Write-1-to-clear for flags (bit0 threshold, bit1 end) |
| irq_en | input | 2 | Per-flag interrupt enables |
| flags | output | 2 | Sticky flags: bit0 threshold reached, bit1 end reached |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties assume that `xfer_ready` is meaningful only while `xfer_valid` is high. They also assume the end address can be reached from the start by steps of 4, so the wrap check sees the end address before any overflow. The stimulus keeps every programmed buffer inside one small window with start below threshold below end. All boundary values are multiples of 4 except those that deliberately test masking and clamping. Configuration writes and `flag_clr` pulses are driven only between clock edges, and each lasts exactly one cycle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    SEL_START = 2'd0,
    SEL_THR   = 2'd1,
    SEL_END   = 2'd2,
    SEL_NONE  = 2'd3
  } cfg_sel_e;

  localparam int unsigned NUM_CFG  = 3;
  localparam int unsigned NUM_FLAG = 2;
  localparam int unsigned FLAG_THR = 0;
  localparam int unsigned FLAG_END = 1;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_seq_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]  MIN_ADDR = 32'h2000_0000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [1:0]                    sel,
  input  logic [ADDR_W-1:0]             wdata,
  output logic [NUM_CFG-1:0][ADDR_W-1:0] cfg_q
);
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] legal;

  always_comb begin
    aligned = {wdata[ADDR_W-1:2], 2'b00};
    legal   = (aligned < MIN_ADDR) ? MIN_ADDR : aligned;
  end

  for (genvar i = 0; i < NUM_CFG; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cfg_q[i] <= MIN_ADDR;
      else if (we && sel == 2'(i))      cfg_q[i] <= legal;
    end

    p_legal_cfg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel == 2'(i)) |=> (cfg_q[i][1:0] == 2'b00 && cfg_q[i] >= MIN_ADDR));
  end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int unsigned        ADDR_W   = 32,
  parameter int unsigned        STEP     = 4,
  parameter logic [ADDR_W-1:0]  MIN_ADDR = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic [ADDR_W-1:0] start_cfg,
  input  logic [ADDR_W-1:0] end_cfg,
  input  logic              fire,
  output logic              armed,
  output logic [ADDR_W-1:0] cur
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic [ADDR_W-1:0] lat_start;
  logic              rise;
  logic              at_end;

  assign rise   = dma_en && !armed;
  assign at_end = (cur == end_cfg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      lat_start <= MIN_ADDR;
      cur       <= MIN_ADDR;
    end else begin
      armed <= dma_en;
      if (rise) begin
        lat_start <= start_cfg;
        cur       <= start_cfg;
      end else if (fire) begin
        cur <= at_end ? lat_start : cur + STEP_V;
      end
    end
  end

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (cur == $past(start_cfg)));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dma_en && !fire) |=> $stable(cur));
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !rise && !at_end) |=> (cur == $past(cur) + STEP_V));
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !rise && at_end) |=> (cur == $past(lat_start)));
  p_keep_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && dma_en) |=> $stable(lat_start));
endmodule

// File: rtl/dma_match_flags.sv
module dma_match_flags
  import dma_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            armed,
  input  logic [ADDR_W-1:0]               cur,
  input  logic [NUM_FLAG-1:0][ADDR_W-1:0] target,
  input  logic [NUM_FLAG-1:0]             clr,
  input  logic [NUM_FLAG-1:0]             ie,
  output logic [NUM_FLAG-1:0]             flag,
  output logic                            irq
);
  logic [NUM_FLAG-1:0] hit;
  logic [NUM_FLAG-1:0] hit_q;
  logic [NUM_FLAG-1:0] arrive;

  for (genvar i = 0; i < NUM_FLAG; i++) begin : g_flag
    assign hit[i]    = armed && (cur == target[i]);
    assign arrive[i] = hit[i] && !hit_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q[i] <= 1'b0;
        flag[i]  <= 1'b0;
      end else begin
        hit_q[i] <= hit[i];
        if (arrive[i])   flag[i] <= 1'b1;
        else if (clr[i]) flag[i] <= 1'b0;
      end
    end

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[i] && !clr[i]) |=> flag[i]);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !arrive[i]) |=> !flag[i]);
    p_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag[i] && hit_q[i] && hit[i]) |=> !flag[i]);
  end

  assign irq = |(flag & ie);
endmodule

// File: rtl/dma_circ_seq.sv
module dma_circ_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 32,
  parameter int unsigned        STEP     = 4,
  parameter logic [ADDR_W-1:0]  MIN_ADDR = 32'h2000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic              dma_en,
  input  logic              fifo_req,
  output logic              xfer_valid,
  input  logic              xfer_ready,
  output logic [ADDR_W-1:0] cur_addr,
  input  logic [1:0]        flag_clr,
  input  logic [1:0]        irq_en,
  output logic [1:0]        flags,
  output logic              irq
);
  logic [NUM_CFG-1:0][ADDR_W-1:0]  cfg_q;
  logic [NUM_FLAG-1:0][ADDR_W-1:0] targets;
  logic                            armed;
  logic                            fire;

  dma_cfg_regs #(.ADDR_W(ADDR_W), .MIN_ADDR(MIN_ADDR)) u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we),
    .sel   (reg_sel),
    .wdata (reg_wdata),
    .cfg_q (cfg_q)
  );

  assign xfer_valid = dma_en && armed && fifo_req;
  assign fire       = xfer_valid && xfer_ready;

  dma_addr_gen #(.ADDR_W(ADDR_W), .STEP(STEP), .MIN_ADDR(MIN_ADDR)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .dma_en    (dma_en),
    .start_cfg (cfg_q[SEL_START]),
    .end_cfg   (cfg_q[SEL_END]),
    .fire      (fire),
    .armed     (armed),
    .cur       (cur_addr)
  );

  assign targets[FLAG_THR] = cfg_q[SEL_THR];
  assign targets[FLAG_END] = cfg_q[SEL_END];

  dma_match_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .armed  (armed),
    .cur    (cur_addr),
    .target (targets),
    .clr    (flag_clr),
    .ie     (irq_en),
    .flag   (flags),
    .irq    (irq)
  );

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> $stable(cur_addr));
  p_backpressure_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> $stable(cur_addr));
endmodule

// File: tb/dma_circ_seq_test.sv
module dma_circ_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic        dma_en = 1'b0;
  logic        fifo_req = 1'b0;
  logic        xfer_valid;
  logic        xfer_ready = 1'b0;
  logic [31:0] cur_addr;
  logic [1:0]  flag_clr = 2'b00;
  logic [1:0]  irq_en = 2'b00;
  logic [1:0]  flags;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dma_circ_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dma_en(dma_en), .fifo_req(fifo_req),
    .xfer_valid(xfer_valid), .xfer_ready(xfer_ready), .cur_addr(cur_addr),
    .flag_clr(flag_clr), .irq_en(irq_en), .flags(flags), .irq(irq)
  );

  // {req, ready, expected cur_addr, expected flags {end,thr}, expected valid}
  localparam int NVEC = 9;
  localparam logic [36:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 32'h2000_0104, 2'b00, 1'b1},
    {1'b1, 1'b0, 32'h2000_0104, 2'b00, 1'b1},
    {1'b0, 1'b1, 32'h2000_0104, 2'b00, 1'b0},
    {1'b1, 1'b1, 32'h2000_0108, 2'b00, 1'b1},
    {1'b0, 1'b0, 32'h2000_0108, 2'b01, 1'b0},
    {1'b1, 1'b1, 32'h2000_010C, 2'b01, 1'b1},
    {1'b0, 1'b0, 32'h2000_010C, 2'b11, 1'b0},
    {1'b1, 1'b1, 32'h2000_0100, 2'b11, 1'b1},
    {1'b1, 1'b1, 32'h2000_0104, 2'b11, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] val);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    tick();
    reg_we = 1'b0;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 cur", cur_addr, 32'h2000_0000);
    chk("R1 flags", {30'd0, flags}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 valid", {31'd0, xfer_valid}, 32'd0);
    rst_n = 1'b1;
    tick();

    // R2: low bits dropped on start; reg_sel 3 ignored
    wr(2'd0, 32'h2000_0103);
    wr(2'd1, 32'h2000_0108);
    wr(2'd2, 32'h2000_010C);
    wr(2'd3, 32'h2000_0000);
    dma_en = 1'b1;
    tick();
    chk("R3 load start (R2 masked)", cur_addr, 32'h2000_0100);

    // table walk: R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      fifo_req   = VEC[i][36];
      xfer_ready = VEC[i][35];
      #1;
      chk("R5 valid", {31'd0, xfer_valid}, {31'd0, VEC[i][0]});
      tick();
      chk("R6 R7 addr", cur_addr, VEC[i][34:3]);
      chk("R8 flags", {30'd0, flags}, {30'd0, VEC[i][2:1]});
    end
    fifo_req = 1'b0; xfer_ready = 1'b0;

    // R10 clear both
    flag_clr = 2'b11; tick(); flag_clr = 2'b00;
    chk("R10 cleared", {30'd0, flags}, 32'd0);
    tick();
    chk("R10 zero clr keeps", {30'd0, flags}, 32'd0);

    // reach threshold again
    fifo_req = 1'b1; xfer_ready = 1'b1; tick();
    fifo_req = 1'b0; xfer_ready = 1'b0; tick();
    chk("R8 thr again", {30'd0, flags}, 32'd1);
    irq_en = 2'b01; #1;
    chk("R11 irq on", {31'd0, irq}, 32'd1);
    irq_en = 2'b10; #1;
    chk("R11 irq masked", {31'd0, irq}, 32'd0);

    // R9 clear while still at threshold
    flag_clr = 2'b01; tick(); flag_clr = 2'b00;
    tick(); tick(); tick();
    chk("R9 no retrigger", {30'd0, flags}, 32'd0);
    chk("R9 still at thr", cur_addr, 32'h2000_0108);

    // R4 start write while enabled
    wr(2'd0, 32'h2000_0200);
    chk("R4 cur unchanged", cur_addr, 32'h2000_0108);
    fifo_req = 1'b1; xfer_ready = 1'b1; tick(); tick();
    fifo_req = 1'b0; xfer_ready = 1'b0;
    chk("R7 R4 wrap to old start", cur_addr, 32'h2000_0100);
    chk("R8 end set", {31'd0, flags[1]}, 32'd1);
    irq_en = 2'b10; #1;
    chk("R11 end irq", {31'd0, irq}, 32'd1);

    // R12 disable
    dma_en = 1'b0; fifo_req = 1'b1; xfer_ready = 1'b1; #1;
    chk("R12 valid drops", {31'd0, xfer_valid}, 32'd0);
    tick(); tick();
    chk("R12 cur frozen", cur_addr, 32'h2000_0100);
    fifo_req = 1'b0; xfer_ready = 1'b0;

    // R3 re-enable picks new start
    dma_en = 1'b1; #1;
    chk("R3 no valid on rise", {31'd0, xfer_valid}, 32'd0);
    tick();
    chk("R3 new start", cur_addr, 32'h2000_0200);

    // R2 clamp
    dma_en = 1'b0; tick();
    wr(2'd0, 32'h0000_1236);
    dma_en = 1'b1; tick();
    chk("R2 clamp", cur_addr, 32'h2000_0000);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule